// File: doc/BRIEF.md
# Serial Converter Host Reader

This block drives a 16-bit serial analog-to-digital converter from the host side of a three-wire link: an active-low chip select, a serial clock that it generates, and one serial data input. The serial clock is made from the system clock by a divider. The clock idles low. The converter changes its data on rising edges, and the host takes each bit on a falling edge.

After reset, the first request makes the block send a short initialization frame. Chip select stays low for a parameterised number of falling edges, from one to eight. After that the block runs normal frames. Each one holds chip select low for 24 falling edges, and the first 16 of those carry a result, most significant bit first. Every word belongs to the sample taken in the frame before it. For that reason the word read in the first normal frame after initialization is dropped. That word is normally the converter's reset code FF00h.

After every frame, chip select stays high for a fixed number of system clocks, so that the conversion can finish. Each later word is presented for one cycle with a valid strobe. A word equal to FF00h also raises an error flag for that cycle, since it means a conversion was cut short. The block runs one frame per start pulse, or it runs frames back to back while the continuous enable is high.

Top module: `adc_frame_host`

## Requirements
- R1: During and right after reset, chip select is high (1), the serial clock is low, and valid and error are low.
- R2: The serial clock is low whenever chip select is high. While chip select is low, every high phase and every low phase lasts exactly DIV_HALF system clocks. This includes the low phase from the chip-select fall to the first rise and the low phase from the last fall to the chip-select rise.
- R3: The first frame after reset is an initialization frame with exactly INIT_EDGES falling serial-clock edges while chip select is low.
- R4: Every normal frame has exactly 24 falling serial-clock edges while chip select is low.
- R5: In a normal frame, the 16 bits sampled on falling edges 1 to 16 form the output word. The bit from edge 1 goes to bit 15, the most significant bit.
- R6: Chip select stays high for at least GAP_CYC system clocks between the end of one frame and the fall of the next.
- R7: The first normal frame after initialization produces no valid pulse, whatever its data, and it starts on its own after initialization.
- R8: Every later normal frame produces exactly one valid pulse, one system clock long, with the received word on word_o.
- R9: The error output pulses together with valid exactly when the delivered word is 16'hFF00. A 16'hFF00 in the dropped first frame raises no error.
- R10: With cont_i high, frames follow one another after each gap. With cont_i low, the block goes idle after the current frame and starts nothing until start_i is pulsed. A later start runs a single normal frame with no new initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one frame while idle |
| cont_i | input | 1 | Keep running frames back to back |
| sdi_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Generated serial clock, idles low |
| cs_n_o | output | 1 | Active-low chip select |
| word_o | output | 16 | Last received result word |
| valid_o | output | 1 | One-cycle strobe for word_o |
| err_o | output | 1 | One-cycle flag: delivered word was FF00h |

## Verification
The bench targets three things.

- **Discard and initialization.** A reader that forgot to drop the first word would deliver FF00h first with the error flag raised. A reader that repeated initialization on a later start would show an initialization-length frame where a 24-edge frame belongs.
- **Frame timing.** The bench measures frame length, phase widths and the chip-select gap on the pins. An off-by-one edge counter, a shortened tail phase or a gap counter that ends early each shows up as a wrong count.
- **Data path.** The bench feeds words with all-ones, all-zeros and single set bits at either end, plus FF00h in the middle of a continuous run. These expose bit-order reversal, a sampling edge shifted by one, and an error flag tied to the wrong condition.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_FRAME,
    ST_TAIL,
    ST_GAP
  } host_state_t;

endpackage

// File: rtl/adc_sclk_gen.sv
// Serial clock divider: toggles every DIV_HALF system clocks while run_i is high
module adc_sclk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o
);

  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

  logic [DW-1:0] div_q;
  logic          wrap;

  assign wrap   = run_i && (div_q == DIV_LAST);
  // falling edge happens at the clock edge where a high sclk wraps
  assign fall_o = wrap && sclk_o;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      div_q  <= '0;
      sclk_o <= 1'b0;
    end else if (wrap) begin
      div_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_rx_shift.sv
// Registers the serial input, shifts it MSB first and presents finished words
module adc_rx_shift #(
  parameter int              W        = 16,
  parameter logic [W-1:0]    ERR_WORD = 16'hFF00
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdi_i,
  input  logic         shift_i,
  input  logic         last_i,
  input  logic         keep_i,
  output logic [W-1:0] word_o,
  output logic         valid_o,
  output logic         err_o
);

  logic         sdi_q;
  logic [W-1:0] sr_q;
  logic         pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdi_q   <= 1'b0;
      sr_q    <= '0;
      pend_q  <= 1'b0;
      word_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      sdi_q   <= sdi_i;
      if (shift_i) sr_q <= {sr_q[W-2:0], sdi_q};
      pend_q  <= last_i && keep_i;
      valid_o <= pend_q;
      err_o   <= pend_q && (sr_q == ERR_WORD);
      if (pend_q) word_o <= sr_q;
    end
  end

  // R8: a delivered word is strobed for one cycle only
  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R9: the error flag only accompanies a delivered reserved word
  p_err_word_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (valid_o && word_o == ERR_WORD));

endmodule

// File: rtl/adc_frame_host.sv
// Frame sequencer for a 16-bit serial converter: init frame, discard, read frames
module adc_frame_host
  import adc_host_pkg::*;
#(
  parameter int DIV_HALF    = 4,
  parameter int INIT_EDGES  = 4,
  parameter int FRAME_EDGES = 24,
  parameter int WORD_W      = 16,
  parameter int GAP_CYC     = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              err_o
);

  localparam int EW   = $clog2(FRAME_EDGES + 1);
  localparam int GMAX = (GAP_CYC > DIV_HALF) ? GAP_CYC : DIV_HALF;
  localparam int GW   = $clog2(GMAX + 1);
  localparam logic [EW-1:0] INIT_LAST  = EW'(INIT_EDGES - 1);
  localparam logic [EW-1:0] FRAME_LAST = EW'(FRAME_EDGES - 1);
  localparam logic [EW-1:0] WORD_LAST  = EW'(WORD_W - 1);
  localparam logic [EW-1:0] WORD_CNT   = EW'(WORD_W);
  localparam logic [GW-1:0] TAIL_LOAD  = GW'(DIV_HALF - 1);
  localparam logic [GW-1:0] GAP_LOAD   = GW'(GAP_CYC - 1);
  localparam logic [GW-1:0] GAP_FULL   = GW'(GAP_CYC);
  localparam logic [WORD_W-1:0] ERR_WORD = WORD_W'(16'hFF00);

  host_state_t   state_q;
  logic          cs_n_q;
  logic          inited_q;
  logic          primed_q;
  logic [EW-1:0] edge_q;
  logic [GW-1:0] gcnt_q;
  logic          run_w;
  logic          sclk_w;
  logic          fall_w;
  logic [EW-1:0] last_idx;
  logic          in_frame;

  assign in_frame = (state_q == ST_FRAME);
  assign run_w    = (state_q == ST_INIT) || in_frame;
  assign last_idx = (state_q == ST_INIT) ? INIT_LAST : FRAME_LAST;

  adc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run_w),
    .sclk_o (sclk_w),
    .fall_o (fall_w)
  );

  adc_rx_shift #(.W(WORD_W), .ERR_WORD(ERR_WORD)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .sdi_i   (sdi_i),
    .shift_i (in_frame && fall_w && (edge_q < WORD_CNT)),
    .last_i  (in_frame && fall_w && (edge_q == WORD_LAST)),
    .keep_i  (primed_q),
    .word_o  (word_o),
    .valid_o (valid_o),
    .err_o   (err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cs_n_q   <= 1'b1;
      inited_q <= 1'b0;
      primed_q <= 1'b0;
      edge_q   <= '0;
      gcnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i || cont_i) begin
            cs_n_q  <= 1'b0;
            edge_q  <= '0;
            state_q <= inited_q ? ST_FRAME : ST_INIT;
          end
        end
        ST_INIT, ST_FRAME: begin
          if (fall_w) begin
            edge_q <= edge_q + 1'b1;
            if (edge_q == last_idx) begin
              state_q <= ST_TAIL;
              gcnt_q  <= TAIL_LOAD;
              if (in_frame) primed_q <= 1'b1;
              else          inited_q <= 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (gcnt_q == '0) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_GAP;
            gcnt_q  <= GAP_LOAD;
          end else begin
            gcnt_q <= gcnt_q - 1'b1;
          end
        end
        ST_GAP: begin
          if (gcnt_q == '0) begin
            if (!primed_q || cont_i) begin
              cs_n_q  <= 1'b0;
              edge_q  <= '0;
              state_q <= ST_FRAME;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            gcnt_q <= gcnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_w;

  // checker state: cycles chip select has been high, saturating at GAP_CYC
  logic [GW-1:0] hi_cnt_q;
  logic          seen_frame_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q     <= '0;
      seen_frame_q <= 1'b0;
    end else if (!cs_n_q) begin
      hi_cnt_q     <= '0;
      seen_frame_q <= 1'b1;
    end else if (hi_cnt_q != GAP_FULL) begin
      hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  // R6: conversion wait honoured before every later chip-select fall
  p_conv_gap_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n_q) && seen_frame_q) |-> (hi_cnt_q == GAP_FULL));

  // R2: the divider never leaves the clock high outside a frame
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> !sclk_w);

  // R4: the edge counter never runs past a frame
  p_edge_bound_r4: assert property (@(posedge clk) disable iff (rst)
    in_frame |-> (edge_q < EW'(FRAME_EDGES)));

  // R7: nothing is delivered before the discard frame completed
  p_no_early_word_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> primed_q);

endmodule

// File: tb/test_adc_frame_host.sv
module test_adc_frame_host;

  localparam int CLK_P = 10;
  localparam int DIV   = 3;
  localparam int INITE = 4;
  localparam int GAP   = 40;

  // bit 16 = expected error flag, bits 15:0 = word served by the converter model
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 16'hFF00}, {1'b0, 16'h1234}, {1'b0, 16'hFFFF}, {1'b0, 16'h0000},
    {1'b1, 16'hFF00}, {1'b0, 16'h8001}, {1'b0, 16'hA5C3}, {1'b0, 16'h7FFE}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic cont_i = 1'b0;
  logic sdi = 1'b0;
  logic sclk_o, cs_n_o, valid_o, err_o;
  logic [15:0] word_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_frame_host #(
    .DIV_HALF(DIV), .INIT_EDGES(INITE), .FRAME_EDGES(24), .WORD_W(16), .GAP_CYC(GAP)
  ) i_adc_frame_host (
    .clk(clk), .rst(rst), .start_i(start_i), .cont_i(cont_i), .sdi_i(sdi),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .word_o(word_o), .valid_o(valid_o), .err_o(err_o)
  );

  // converter model: MSB on chip-select fall, next bit on every rise after the first
  logic [15:0] sl_sr = '1;
  int sl_fr = 0;
  int sl_rise = 0;
  always @(negedge cs_n_o) begin
    sl_fr++;
    sl_rise = 0;
    if (sl_fr >= 2) sl_sr = VEC[(sl_fr - 2) % 8][15:0];
    else            sl_sr = '1;
    sdi <= sl_sr[15];
  end
  always @(posedge sclk_o) begin
    sl_rise++;
    if (sl_rise >= 2) begin
      sl_sr = {sl_sr[14:0], 1'b0};
      sdi <= sl_sr[15];
    end
  end

  // pin monitor
  int fr_len [16];
  int fr_num = 0, falls = 0, run_len = 0, hi_len = 0, min_gap = 1000000;
  int phase_err = 0, idle_err = 0, v_total = 0, err_total = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n_o && sclk_o) idle_err++;
      if (!cs_n_o && prev_cs) begin
        if (fr_num > 0 && hi_len < min_gap) min_gap = hi_len;
        falls = 0;
        run_len = 1;
      end else if (!cs_n_o) begin
        if (sclk_o == prev_sclk) run_len++;
        else begin
          if (run_len != DIV) phase_err++;
          run_len = 1;
          if (!sclk_o) falls++;
        end
      end else if (!prev_cs) begin
        if (run_len != DIV) phase_err++;
        if (fr_num < 16) fr_len[fr_num] = falls;
        fr_num++;
        hi_len = 1;
      end else begin
        hi_len++;
      end
      if (valid_o) v_total++;
      if (err_o) err_total++;
      prev_cs = cs_n_o;
      prev_sclk = sclk_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output logic [15:0] w, output logic e, output bit got);
    got = 1'b0;
    w = '0;
    e = 1'b0;
    for (int k = 0; k < 5000 && !got; k++) begin
      @(negedge clk);
      if (valid_o) begin
        got = 1'b1;
        w = word_o;
        e = err_o;
      end
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    logic e;
    bit got;

    repeat (4) @(negedge clk);
    // R1: reset state
    check(cs_n_o == 1'b1, "R1 cs_n", cs_n_o, 1);
    check(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
    check(valid_o == 1'b0 && err_o == 1'b0, "R1 valid/err", {valid_o, err_o}, 0);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    // R10: no request, no frame
    check(fr_num == 0, "R10 idle without start", fr_num, 0);

    // vector walk: continuous mode, discard frame first (R7), then words (R5, R8, R9)
    cont_i = 1'b1;
    for (int i = 1; i < 8; i++) begin
      wait_valid(w, e, got);
      if (i == 7) cont_i = 1'b0;
      check(got, "R8 valid pulse arrives", got, 1);
      check(w == VEC[i][15:0], "R5 word", w, VEC[i][15:0]);
      check(e == VEC[i][16], "R9 error flag", e, VEC[i][16]);
    end

    repeat (3 * GAP + 300) @(negedge clk);
    // R10: with cont low the block went idle after the current frame
    check(fr_num == 9, "R10 stops after cont drop", fr_num, 9);
    check(fr_len[0] == INITE, "R3 init frame edges", fr_len[0], INITE);
    for (int f = 1; f < 9; f++)
      check(fr_len[f] == 24, "R4 normal frame edges", fr_len[f], 24);
    // R7: first normal word dropped, so seven words from eight normal frames
    check(v_total == 7, "R7 discard count", v_total, 7);
    check(err_total == 1, "R9 no error on discarded FF00", err_total, 1);
    check(min_gap >= GAP, "R6 chip-select gap", min_gap, GAP);
    check(phase_err == 0, "R2 phase widths", phase_err, 0);

    // single start: one normal frame, no new init, served word FF00h flags error
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_valid(w, e, got);
    check(got && w == 16'hFF00, "R10 start word", w, 16'hFF00);
    check(e == 1'b1, "R9 FF00 in normal operation", e, 1);
    repeat (3 * GAP + 100) @(negedge clk);
    check(fr_num == 10, "R10 single frame per start", fr_num, 10);
    check(fr_len[9] == 24, "R10 no re-init on later start", fr_len[9], 24);
    check(v_total == 8, "R8 one valid per frame", v_total, 8);
    check(idle_err == 0, "R2 sclk low while deselected", idle_err, 0);
    check(phase_err == 0, "R2 phase widths after start", phase_err, 0);
    finish_run();
  end

endmodule